// File: doc/BRIEF.md
# Timer Compare Match Unit with Interrupt Masking

This block sits beside a free-running up-counter and watches it against three compare registers (channels A, B and D) and a top register that sets the count period. When the counter steps onto a compare value by counting, the channel's flag is raised after a short, fixed synchronisation delay. The counter also raises an overflow flag each time it wraps to zero. Software reaches the counter, the compare values, the top value and an 8-bit mask through one write port selected by `wr_sel`. It clears flags by writing ones to `flag_clr`.

A flag becomes an interrupt request only when its mask bit and the global enable are both high. When several requests are pending, the one with the smallest vector number is offered on `irq_vec`. Pulsing `irq_ack` retires the flag of the offered vector. Counter or compare values that become equal only through a register write never raise a flag.

Top module: `cmp_irq_unit`

## Requirements
- R1: A write of 0, 1 or 2 to the top register (wr_sel=3) stores 3. With top stored as 3, the counter wraps every 4 clock cycles.
- R2: The counter (wr_sel=0 writes it) advances by one per cycle. After holding the top value it returns to 0, and each counted arrival at 0 raises the overflow flag (flag bit 3).
- R3: The flag of a compare channel (A: wr_sel=1, flag bit 0; B: wr_sel=2, flag bit 1; D: wr_sel=4, flag bit 2) is raised when the counter counts onto the channel's compare value.
- R4: Writing the counter to a value equal to a compare register raises no flag for that arrival.
- R5: Writing a compare register, in the same cycle, to the value the counter is counting onto raises no flag for that arrival.
- R6: A flag becomes visible exactly two clock edges after the edge that brought the counter onto the matching value.
- R7: irq_req for a channel is high only while its flag, its mask bit and gie are all one. irq_valid is the OR of irq_req.
- R8: The mask register (wr_sel=5) resets to zero. Bit 7 enables D, bit 6 A, bit 5 B and bit 2 overflow. Bits 4, 3, 1 and 0 are stored but affect no request.
- R9: The offered vector is 3 for A, 4 for overflow, 9 for B and 16 for D. It is 0 when irq_valid is low.
- R10: When several requests are pending, irq_vec shows the smallest of their vector numbers.
- R11: A one on flag_clr bit n clears flag n at the next edge. An irq_ack pulse clears the flag whose vector is offered. A flag stays set otherwise, and a new event in the same cycle as a clear leaves the flag set.
- R12: After reset all flags, requests, irq_valid and irq_vec are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 counter, 1 compare A, 2 compare B, 3 top, 4 compare D, 5 mask |
| wr_data | input | CNT_W | Write data; the mask takes the low 8 bits |
| flag_clr | input | 4 | Write-one-to-clear per flag: bit 0 A, 1 B, 2 D, 3 overflow |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge of the vector currently offered |
| flags | output | 4 | Flag state, same bit order as flag_clr |
| irq_req | output | 4 | Per-flag interrupt request, same bit order |
| irq_valid | output | 1 | At least one request is pending |
| irq_vec | output | 5 | Vector number of the winning request, 0 when none |

## Verification
The hardest case to reach is a flag event that lands on the same edge as a clear of that flag. To reach it, the counter is written to a known value, the stimulus counts edges to the one that will set the flag, and the clear is pulsed exactly there. Suppressed matches need equally precise timing: a compare write has to land on the very edge where the counter steps onto the new value. The bench therefore derives these edges from the written counter value. A behavioural model with an event queue checks every cycle of a long pseudo-random phase that mixes writes, clears, acknowledges and enable changes.

// File: rtl/cmp_irq_pkg.sv
`timescale 1ns/1ps
package cmp_irq_pkg;
  // channel indices: three compare channels then the overflow source
  localparam int NCMP   = 3;
  localparam int NCH    = NCMP + 1;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_D   = 2;
  localparam int CH_OVF = 3;

  localparam int MASK_W = 8;
  localparam int VEC_W  = 5;

  // write port targets
  localparam logic [2:0] SEL_CNT  = 3'd0;
  localparam logic [2:0] SEL_CMPA = 3'd1;
  localparam logic [2:0] SEL_CMPB = 3'd2;
  localparam logic [2:0] SEL_TOP  = 3'd3;
  localparam logic [2:0] SEL_CMPD = 3'd4;
  localparam logic [2:0] SEL_MASK = 3'd5;

  // position of each channel's enable inside the mask register
  function automatic int mask_pos(input int ch);
    case (ch)
      CH_A:    mask_pos = 6;
      CH_B:    mask_pos = 5;
      CH_D:    mask_pos = 7;
      default: mask_pos = 2;
    endcase
  endfunction

  // vector number offered for each channel
  function automatic logic [VEC_W-1:0] chan_vec(input int ch);
    case (ch)
      CH_A:    chan_vec = VEC_W'(3);
      CH_B:    chan_vec = VEC_W'(9);
      CH_D:    chan_vec = VEC_W'(16);
      default: chan_vec = VEC_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/cmp_counter.sv
`timescale 1ns/1ps
module cmp_counter #(
  parameter int CNT_W   = 8,
  parameter int MIN_TOP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic             top_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             counted_q,
  output logic [CNT_W-1:0] top_q
);
  localparam logic [CNT_W-1:0] TOP_MIN = CNT_W'(MIN_TOP);
  localparam logic [CNT_W-1:0] TOP_RST = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             counted_d;
  logic [CNT_W-1:0] top_d;

  always_comb begin
    counted_d = 1'b1;
    if (cnt_we) begin
      cnt_d     = wdata;
      counted_d = 1'b0;
    end else if (cnt_q == top_q) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    top_d = (wdata < TOP_MIN) ? TOP_MIN : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      counted_q <= 1'b0;
      top_q     <= TOP_RST;
    end else begin
      cnt_q     <= cnt_d;
      counted_q <= counted_d;
      if (top_we) top_q <= top_d;
    end
  end

  // R1
  top_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_q >= TOP_MIN);

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cnt_q == top_q) |=> (cnt_q == '0));
endmodule

// File: rtl/cmp_detect.sv
`timescale 1ns/1ps
module cmp_detect
  import cmp_irq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SYNC_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             counted,
  input  logic [NCMP-1:0]  cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [NCH-1:0]   evt
);
  // the flag register downstream is the last synchroniser stage
  localparam int PIPE = SYNC_DLY - 1;

  logic [CNT_W-1:0]          cmp_q [NCMP];
  logic [NCMP-1:0]           cmp_wr_q;
  logic [NCH-1:0]            raw;
  logic [PIPE-1:0][NCH-1:0]  stg_q;
  logic [PIPE-1:0][NCH-1:0]  stg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '{default: '0};
      cmp_wr_q <= '0;
    end else begin
      cmp_wr_q <= cmp_we;
      for (int c = 0; c < NCMP; c++) begin
        if (cmp_we[c]) cmp_q[c] <= wdata;
      end
    end
  end

  // a match counts only when the counter stepped here by counting and
  // the compare value was not just rewritten
  generate
    for (genvar c = 0; c < NCMP; c++) begin : g_hit
      assign raw[c] = counted && !cmp_wr_q[c] && (cnt_q == cmp_q[c]);

      // R5
      cmp_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we[c] |=> ##1 !stg_q[0][c]);
    end
  endgenerate
  assign raw[CH_OVF] = counted && (cnt_q == '0);

  always_comb begin
    stg_d[0] = raw;
    for (int g = 1; g < PIPE; g++) stg_d[g] = stg_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign evt = stg_q[PIPE-1];

  // R4
  cnt_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !counted |=> (stg_q[0] == '0));
endmodule

// File: rtl/cmp_irq_ctl.sv
`timescale 1ns/1ps
module cmp_irq_ctl
  import cmp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    evt,
  input  logic [NCH-1:0]    flag_clr,
  input  logic              mask_we,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              gie,
  input  logic              irq_ack,
  output logic [NCH-1:0]    flags,
  output logic [NCH-1:0]    irq_req,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [NCH-1:0]    flag_q;
  logic [NCH-1:0]    flag_d;
  logic [MASK_W-1:0] mask_q;
  logic [NCH-1:0]    ack_sel;
  logic              found;
  logic [VEC_W-1:0]  best;
  logic              unused_other_bits;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_req
      assign irq_req[c] = flag_q[c] & mask_q[mask_pos(c)] & gie;

      // R11
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[c]) |-> $past(flag_clr[c] || irq_ack));
    end
  endgenerate

  assign unused_other_bits = ^{mask_q[4:3], mask_q[1:0]};

  // smallest vector number wins
  always_comb begin
    found   = 1'b0;
    best    = '0;
    ack_sel = '0;
    for (int c = 0; c < NCH; c++) begin
      if (irq_req[c] && (!found || chan_vec(c) < best)) begin
        found      = 1'b1;
        best       = chan_vec(c);
        ack_sel    = '0;
        ack_sel[c] = 1'b1;
      end
    end
  end

  // a fresh event wins over a clear in the same cycle
  always_comb begin
    flag_d = (flag_q & ~(flag_clr | ({NCH{irq_ack}} & ack_sel))) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign flags     = flag_q;
  assign irq_valid = found;
  assign irq_vec   = best;

  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie);

  // R10
  vec_a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[CH_A] |-> (irq_vec == chan_vec(CH_A)));
endmodule

// File: rtl/cmp_irq_unit.sv
`timescale 1ns/1ps
module cmp_irq_unit
  import cmp_irq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SYNC_DLY = 2,
  parameter int MIN_TOP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [3:0]       flag_clr,
  input  logic             gie,
  input  logic             irq_ack,
  output logic [3:0]       flags,
  output logic [3:0]       irq_req,
  output logic             irq_valid,
  output logic [4:0]       irq_vec
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             cnt_we;
  logic             top_we;
  logic             mask_we;
  logic [NCMP-1:0]  cmp_we;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_q;
  logic             counted;
  logic [NCH-1:0]   evt;
  logic             unused_top;

  // assert at once, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    cnt_we       = wr_en && (wr_sel == SEL_CNT);
    top_we       = wr_en && (wr_sel == SEL_TOP);
    mask_we      = wr_en && (wr_sel == SEL_MASK);
    cmp_we[CH_A] = wr_en && (wr_sel == SEL_CMPA);
    cmp_we[CH_B] = wr_en && (wr_sel == SEL_CMPB);
    cmp_we[CH_D] = wr_en && (wr_sel == SEL_CMPD);
  end

  cmp_counter #(.CNT_W(CNT_W), .MIN_TOP(MIN_TOP)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cnt_we    (cnt_we),
    .top_we    (top_we),
    .wdata     (wr_data),
    .cnt_q     (cnt_q),
    .counted_q (counted),
    .top_q     (top_q)
  );
  assign unused_top = ^top_q;

  cmp_detect #(.CNT_W(CNT_W), .SYNC_DLY(SYNC_DLY)) u_det (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cnt_q   (cnt_q),
    .counted (counted),
    .cmp_we  (cmp_we),
    .wdata   (wr_data),
    .evt     (evt)
  );

  cmp_irq_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .evt        (evt),
    .flag_clr   (flag_clr),
    .mask_we    (mask_we),
    .mask_wdata (wr_data[MASK_W-1:0]),
    .gie        (gie),
    .irq_ack    (irq_ack),
    .flags      (flags),
    .irq_req    (irq_req),
    .irq_valid  (irq_valid),
    .irq_vec    (irq_vec)
  );
endmodule

// File: tb/cmp_irq_unit_bench.sv
`timescale 1ns/1ps
module cmp_irq_unit_bench;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [3:0] flag_clr;
  logic       gie;
  logic       irq_ack;
  logic [3:0] flags;
  logic [3:0] irq_req;
  logic       irq_valid;
  logic [4:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmp_irq_unit u_cmp_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .gie(gie), .irq_ack(irq_ack), .flags(flags),
    .irq_req(irq_req), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         track = 0;
  int         cyc = 0;
  int         m_cnt, m_per;
  bit         m_counted;
  int         m_cmp [3];
  bit         m_cwr [3];
  logic [7:0] m_mask;
  logic [3:0] m_flag;
  int         evq [$];
  int         keep [$];

  initial begin
    m_cnt = 0; m_per = 255; m_counted = 0;
    m_cmp = '{0, 0, 0}; m_cwr = '{0, 0, 0};
    m_mask = 8'h00; m_flag = 4'h0;
  end

  function automatic void model_out(output logic [3:0] r, output logic v,
                                    output logic [4:0] vc, output int w);
    r[0] = m_flag[0] & m_mask[6] & gie;
    r[1] = m_flag[1] & m_mask[5] & gie;
    r[2] = m_flag[2] & m_mask[7] & gie;
    r[3] = m_flag[3] & m_mask[2] & gie;
    v = |r; vc = 5'd0; w = 0;
    if (r[0])      begin vc = 5'd3;  w = 0; end
    else if (r[3]) begin vc = 5'd4;  w = 3; end
    else if (r[1]) begin vc = 5'd9;  w = 1; end
    else if (r[2]) begin vc = 5'd16; w = 2; end
  endfunction

  logic [3:0] mr, nf;
  logic       mv;
  logic [4:0] mvec;
  int         mw;
  bit         cw;

  always @(posedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      model_out(mr, mv, mvec, mw);
      nf = m_flag & ~flag_clr;
      if (irq_ack && mv) nf[mw] = 1'b0;
      keep.delete();
      foreach (evq[i]) begin
        if (evq[i] / 8 == cyc) nf[evq[i] % 8] = 1'b1;
        else keep.push_back(evq[i]);
      end
      evq = keep;
      if (track) begin
        for (int c = 0; c < 3; c++)
          if (m_counted && !m_cwr[c] && m_cnt == m_cmp[c]) evq.push_back((cyc + 1) * 8 + c);
        if (m_counted && m_cnt == 0) evq.push_back((cyc + 1) * 8 + 3);
      end
      m_flag = nf;
      m_cwr = '{0, 0, 0};
      cw = wr_en && wr_sel == 3'd0;
      if (!cw) begin
        m_cnt = (m_cnt == m_per) ? 0 : (m_cnt + 1) % 256;
        m_counted = 1;
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: begin
            m_cnt = int'(wr_data); m_counted = 0;
            if (!track) begin track = 1; m_flag = 4'h0; end
          end
          3'd1: begin m_cmp[0] = int'(wr_data); m_cwr[0] = 1; end
          3'd2: begin m_cmp[1] = int'(wr_data); m_cwr[1] = 1; end
          3'd3: m_per = (wr_data < 8'd3) ? 3 : int'(wr_data);
          3'd4: begin m_cmp[2] = int'(wr_data); m_cwr[2] = 1; end
          3'd5: m_mask = wr_data;
          default: ;
        endcase
      end
    end
  end

  // compare model with design every cycle, away from the active edge
  logic [3:0] er;
  logic       ev;
  logic [4:0] evc;
  int         ew;
  always @(negedge clk) begin
    if (track && !done) begin
      model_out(er, ev, evc, ew);
      chk(flags == m_flag, "R6 flags vs model", int'(flags), int'(m_flag));
      chk(irq_req == er, "R7 irq_req vs model", int'(irq_req), int'(er));
      chk(irq_valid == ev, "R7 irq_valid vs model", int'(irq_valid), int'(ev));
      chk(irq_vec == evc, "R10 irq_vec vs model", int'(irq_vec), int'(evc));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  int t_first, t_second;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'd0;
    flag_clr = 4'h0; gie = 1'b0; irq_ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    // R12 reset state
    chk(flags == 4'h0, "R12 flags after reset", int'(flags), 0);
    chk(irq_req == 4'h0, "R12 irq_req after reset", int'(irq_req), 0);
    chk(!irq_valid, "R12 irq_valid after reset", int'(irq_valid), 0);
    chk(irq_vec == 5'd0, "R12 irq_vec after reset", int'(irq_vec), 0);

    // R6 / R3: counter written to 30, compare A at 40 -> counter at 40 after 10 edges, flag two edges later
    tick();
    wr(3'd1, 8'd40);
    wr(3'd0, 8'd30);
    idle(11);
    @(negedge clk);
    chk(flags[0] == 1'b0, "R6 flag A one edge after match", int'(flags[0]), 0);
    tick();
    @(negedge clk);
    chk(flags[0] == 1'b1, "R3 R6 flag A two edges after match", int'(flags[0]), 1);

    // R4: counter written onto compare B value
    wr(3'd2, 8'd100);
    flag_clr = 4'hF;
    wr(3'd0, 8'd100);
    flag_clr = 4'h0;
    idle(5);
    @(negedge clk);
    chk(flags[1] == 1'b0, "R4 no flag B after counter write", int'(flags[1]), 0);

    // R5: compare D written on the edge where the counter counts onto it
    wr(3'd0, 8'd20);
    wr(3'd4, 8'd21);
    idle(5);
    @(negedge clk);
    chk(flags[2] == 1'b0, "R5 no flag D after compare write", int'(flags[2]), 0);

    // R1 / R2: top written as 1 is stored as 3, wrap every 4 cycles
    wr(3'd3, 8'd1);
    wr(3'd0, 8'd0);
    t_first = -1; t_second = -1;
    for (int k = 0; k < 20; k++) begin
      flag_clr = flags[3] ? 4'b1000 : 4'b0000;
      tick();
      flag_clr = 4'h0;
      @(negedge clk);
      if (flags[3]) begin
        if (t_first < 0) t_first = k;
        else if (t_second < 0) t_second = k;
      end
    end
    chk(t_first >= 0, "R2 overflow flag raised", t_first, 0);
    chk(t_second - t_first == 4, "R1 wrap period with clamped top", t_second - t_first, 4);

    // raise all four flags with gie low
    tick();
    wr(3'd3, 8'd255);
    wr(3'd1, 8'd10);
    wr(3'd2, 8'd20);
    wr(3'd4, 8'd30);
    wr(3'd5, 8'hE4);
    wr(3'd0, 8'd250);
    idle(2);
    flag_clr = 4'hF; tick(); flag_clr = 4'h0;
    idle(45);
    @(negedge clk);
    chk(flags == 4'hF, "R2 R3 all flags set", int'(flags), 15);
    chk(irq_req == 4'h0, "R7 no request with gie low", int'(irq_req), 0);
    chk(!irq_valid, "R7 irq_valid low with gie low", int'(irq_valid), 0);
    chk(irq_vec == 5'd0, "R9 vector zero when none valid", int'(irq_vec), 0);

    tick();
    gie = 1'b1;
    wr(3'd5, 8'h40);
    @(negedge clk);
    chk(irq_req == 4'b0001, "R8 mask bit 6 enables A", int'(irq_req), 1);
    chk(irq_vec == 5'd3, "R9 vector of A", int'(irq_vec), 3);
    tick();
    wr(3'd5, 8'h1B);
    @(negedge clk);
    chk(irq_req == 4'h0, "R8 bits 4,3,1,0 enable nothing", int'(irq_req), 0);
    tick();
    wr(3'd5, 8'h80);
    @(negedge clk);
    chk(irq_req == 4'b0100, "R8 mask bit 7 enables D", int'(irq_req), 4);
    chk(irq_vec == 5'd16, "R9 vector of D", int'(irq_vec), 16);
    tick();
    wr(3'd5, 8'h20);
    @(negedge clk);
    chk(irq_vec == 5'd9, "R9 vector of B", int'(irq_vec), 9);
    tick();
    wr(3'd5, 8'h04);
    @(negedge clk);
    chk(irq_vec == 5'd4, "R9 vector of overflow", int'(irq_vec), 4);
    tick();
    wr(3'd5, 8'hE4);
    @(negedge clk);
    chk(irq_vec == 5'd3, "R10 lowest vector first (A)", int'(irq_vec), 3);
    tick();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    @(negedge clk);
    chk(irq_vec == 5'd4, "R10 R11 after ack A, overflow next", int'(irq_vec), 4);
    tick();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    @(negedge clk);
    chk(irq_vec == 5'd9, "R10 R11 after ack overflow, B next", int'(irq_vec), 9);
    tick();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    @(negedge clk);
    chk(irq_vec == 5'd16, "R10 R11 after ack B, D next", int'(irq_vec), 16);
    tick();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    @(negedge clk);
    chk(!irq_valid && flags == 4'h0, "R11 all flags retired by ack", int'(flags), 0);

    // R11: clear on the very edge that sets the flag -> flag stays set
    tick();
    wr(3'd0, 8'd0);
    idle(11);
    flag_clr = 4'b0001; tick(); flag_clr = 4'h0;
    @(negedge clk);
    chk(flags[0] == 1'b1, "R11 event wins over same-edge clear", int'(flags[0]), 1);
    tick();
    flag_clr = 4'b0001; tick(); flag_clr = 4'h0;
    @(negedge clk);
    chk(flags[0] == 1'b0, "R11 write-one clears flag", int'(flags[0]), 0);

    // mixed pseudo-random traffic, model compared every cycle
    tick();
    wr(3'd3, 8'd23);
    for (int k = 0; k < 2000; k++) begin
      int unsigned rv;
      rv = $urandom;
      wr_en    = (rv[3:0] == 4'd0);
      wr_sel   = rv[6:4];
      wr_data  = rv[14:7];
      flag_clr = (rv[17:15] == 3'd0) ? rv[21:18] : 4'h0;
      irq_ack  = (rv[24:22] == 3'd0);
      if (rv[29:25] == 5'd0) gie = ~gie;
      tick();
    end
    wr_en = 1'b0; flag_clr = 4'h0; irq_ack = 1'b0;
    idle(4);
    finish_run();
  end
endmodule